// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared 8K x 16 two-port memory. Each clock it samples the enable and 13-bit address of the left and right ports. When both ports are enabled on the same location, it marks exactly one port busy: the port whose access turned up later. The port that was already settled keeps its access. A write qualifier for each port lets the memory's write strobes through only while that port is not busy. The memory array itself is outside this block.

In master mode the block works out busy on its own and drives both busy outputs at every level, high or low. In slave mode the busy information comes from an external master through two busy inputs. Those inputs then gate the writes, and the block holds its own busy outputs low. Each port remembers the enable and address it presented in the previous cycle, and arrival order is judged from that history. Once a port owns a matching location, it keeps priority until the match ends. When both ports start the same match in the same cycle, the right port is marked busy.

Top module: `dpca_collision_arbiter`

## Requirements
- R1: A busy output can assert only after a sampled cycle in which both enables were high and the two 13-bit addresses were equal. In every other case both busy outputs are low.
- R2: When a match starts and only one port changed its enable or address in that cycle, the port that changed is marked busy. The unchanged port is not marked busy.
- R3: The two busy outputs are never high in the same cycle.
- R4: When a match starts and both ports changed their enable or address in that cycle, the right port is marked busy and the left is not.
- R5: Once a port is busy, it stays busy, and the other port stays free, for as long as the match continues in every sampled cycle.
- R6: In master mode (`master_mode`=1), `X_wr_ok` equals `X_wr` AND `X_en` AND NOT `X_busy_out` for each port X.
- R7: In slave mode (`master_mode`=0), both busy outputs are low and `X_wr_ok` equals `X_wr` AND `X_en` AND NOT `X_busy_in`. The internal arbitration result has no effect.
- R8: While reset is asserted, both busy outputs and both write qualifiers are low.
- R9: A busy output reflects the inputs sampled at the previous rising clock edge. It rises and falls one clock after the match begins or ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master (drives busy), 0 = slave (busy from inputs) |
| left_en | input | 1 | Left port enable |
| left_addr | input | 13 | Left port address |
| left_wr | input | 1 | Left port write request |
| left_busy_in | input | 1 | External busy for left port, used in slave mode |
| right_en | input | 1 | Right port enable |
| right_addr | input | 13 | Right port address |
| right_wr | input | 1 | Right port write request |
| right_busy_in | input | 1 | External busy for right port, used in slave mode |
| left_busy_out | output | 1 | Left port busy, driven high and low |
| right_busy_out | output | 1 | Right port busy, driven high and low |
| left_wr_ok | output | 1 | Qualified left write enable |
| right_wr_ok | output | 1 | Qualified right write enable |

## Verification
The hardest case to reach is a match that begins on an address where one port has already been parked for a cycle. Arrival order is decided only from the previous-cycle history, so it depends on what the port presented before, not on the current inputs. The stimulus parks one port on an address or moves it away, then brings the other port onto that address. It also moves both ports onto a new shared address in the same cycle. The tie is entered from different starting points: from a disabled port and from a port that was on a different address. The bench also changes addresses just before a clock edge to show the one-cycle latency, and it gates writes while holding the internal result in the opposite state.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  localparam int ADDR_W = 13;

  typedef enum logic [1:0] {
    OWN_NONE   = 2'b00,
    OWN_L_BUSY = 2'b01,
    OWN_R_BUSY = 2'b10
  } own_e;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
  } port_req_t;
endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track
  import dpca_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_req_t req,
  output logic      steady
);
  port_req_t prev_q, prev_d;

  always_comb begin
    prev_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign steady = (prev_q == req);
endmodule

// File: rtl/dpca_arb_core.sv
module dpca_arb_core
  import dpca_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic steady_l,
  input  logic steady_r,
  output logic busy_l,
  output logic busy_r
);
  own_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    if (!match)                   own_d = OWN_NONE;
    else if (own_q != OWN_NONE)   own_d = own_q;
    else if (steady_l && !steady_r) own_d = OWN_R_BUSY;
    else if (steady_r && !steady_l) own_d = OWN_L_BUSY;
    else                          own_d = OWN_R_BUSY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign busy_l = (own_q == OWN_L_BUSY);
  assign busy_r = (own_q == OWN_R_BUSY);

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l && busy_r));
  a_r1_no_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> (!busy_l && !busy_r));
  a_r5_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && match) |=> (busy_r && !busy_l));
  a_r5_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l && match) |=> (busy_l && !busy_r));
  a_r4_tie_right: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !busy_l && !busy_r && !steady_l && !steady_r) |=> busy_r);
endmodule

// File: rtl/dpca_wr_gate.sv
module dpca_wr_gate (
  input  logic master_mode,
  input  logic en,
  input  logic wr,
  input  logic busy_int,
  input  logic busy_ext,
  output logic wr_ok
);
  logic busy_eff;

  always_comb begin
    busy_eff = master_mode ? busy_int : busy_ext;
    wr_ok    = wr && en && !busy_eff;
  end
endmodule

// File: rtl/dpca_collision_arbiter.sv
module dpca_collision_arbiter
  import dpca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              left_en,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              left_wr,
  input  logic              left_busy_in,
  input  logic              right_en,
  input  logic [ADDR_W-1:0] right_addr,
  input  logic              right_wr,
  input  logic              right_busy_in,
  output logic              left_busy_out,
  output logic              right_busy_out,
  output logic              left_wr_ok,
  output logic              right_wr_ok
);
  localparam int NPORT = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  port_req_t  req   [NPORT];
  logic [NPORT-1:0] steady;
  logic [NPORT-1:0] en_v, wr_v, bext_v, bint_v, ok_v;
  logic match, busy_l, busy_r;

  assign req[0] = '{en: left_en,  addr: left_addr};
  assign req[1] = '{en: right_en, addr: right_addr};
  assign en_v   = {right_en, left_en};
  assign wr_v   = {right_wr, left_wr};
  assign bext_v = {right_busy_in, left_busy_in};
  assign bint_v = {busy_r, busy_l};
  assign match  = left_en && right_en && (left_addr == right_addr);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpca_port_track u_trk (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .req    (req[p]),
      .steady (steady[p])
    );
    dpca_wr_gate u_gate (
      .master_mode (master_mode),
      .en          (en_v[p] && rst_core_n),
      .wr          (wr_v[p]),
      .busy_int    (bint_v[p]),
      .busy_ext    (bext_v[p]),
      .wr_ok       (ok_v[p])
    );
  end

  dpca_arb_core u_core (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .match    (match),
    .steady_l (steady[0]),
    .steady_r (steady[1]),
    .busy_l   (busy_l),
    .busy_r   (busy_r)
  );

  assign left_busy_out  = master_mode && busy_l;
  assign right_busy_out = master_mode && busy_r;
  assign left_wr_ok     = ok_v[0];
  assign right_wr_ok    = ok_v[1];

  a_r3_outs_exclusive: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(left_busy_out && right_busy_out));
  a_r6_left_gated: assert property (@(posedge clk) disable iff (!rst_core_n)
    (master_mode && left_busy_out) |-> !left_wr_ok);
  a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    !master_mode |-> (!left_busy_out && !right_busy_out));
  a_r2_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(busy_l) |-> $past(match));
endmodule

// File: tb/dpca_collision_arbiter_test.sv
module dpca_collision_arbiter_test;
  logic clk = 1'b0;
  logic rst_n;
  logic master_mode;
  logic left_en, right_en, left_wr, right_wr, left_busy_in, right_busy_in;
  logic [12:0] left_addr, right_addr;
  logic left_busy_out, right_busy_out, left_wr_ok, right_wr_ok;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpca_collision_arbiter uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .left_en(left_en), .left_addr(left_addr), .left_wr(left_wr),
    .left_busy_in(left_busy_in),
    .right_en(right_en), .right_addr(right_addr), .right_wr(right_wr),
    .right_busy_in(right_busy_in),
    .left_busy_out(left_busy_out), .right_busy_out(right_busy_out),
    .left_wr_ok(left_wr_ok), .right_wr_ok(right_wr_ok)
  );

  // {len, laddr, ren, raddr, exp bl, br, wl, wr}; writes requested on both ports
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 13'h0005, 1'b0, 13'h0000, 4'b0010}, // R1 one port off
    {1'b1, 13'h0005, 1'b1, 13'h0005, 4'b0110}, // R2 right arrives later
    {1'b1, 13'h0005, 1'b1, 13'h0005, 4'b0110}, // R5 held
    {1'b1, 13'h0005, 1'b1, 13'h0006, 4'b0011}, // R1 addresses differ
    {1'b1, 13'h0006, 1'b1, 13'h0006, 4'b1001}, // R2 left arrives later
    {1'b1, 13'h0006, 1'b1, 13'h0006, 4'b1001}, // R5 held
    {1'b0, 13'h0006, 1'b1, 13'h0006, 4'b0001}, // R1 left disabled
    {1'b1, 13'h0009, 1'b1, 13'h0009, 4'b0110}, // R4 both change together
    {1'b0, 13'h0009, 1'b0, 13'h0009, 4'b0000}, // R1 both off
    {1'b1, 13'h1FFF, 1'b1, 13'h1FFE, 4'b0011}, // R1 near top, differ
    {1'b1, 13'h1FFF, 1'b1, 13'h1FFF, 4'b0110}  // R2 right moves onto left
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic le, input logic [12:0] la,
                       input logic re, input logic [12:0] ra);
    left_en = le; left_addr = la; right_en = re; right_addr = ra;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; master_mode = 1'b1;
    left_wr = 1'b1; right_wr = 1'b1;
    left_busy_in = 1'b0; right_busy_in = 1'b0;
    drive(1'b1, 13'h0003, 1'b1, 13'h0003);
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state with a match present
    chk("R8 bl", left_busy_out, 1'b0);
    chk("R8 br", right_busy_out, 1'b0);
    chk("R8 wl", left_wr_ok, 1'b0);
    chk("R8 wr", right_wr_ok, 1'b0);
    @(negedge clk);
    drive(1'b0, 13'h0000, 1'b0, 13'h0000);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][31], VEC[i][30:18], VEC[i][17], VEC[i][16:4]);
      @(posedge clk); #1;
      chk($sformatf("R1/R2/R4/R5 v%0d bl", i), left_busy_out,  VEC[i][3]);
      chk($sformatf("R3 v%0d br", i),          right_busy_out, VEC[i][2]);
      chk($sformatf("R6 v%0d wl", i),          left_wr_ok,     VEC[i][1]);
      chk($sformatf("R6 v%0d wr", i),          right_wr_ok,    VEC[i][0]);
      chk($sformatf("R3 v%0d excl", i), left_busy_out & right_busy_out, 1'b0);
    end

    // R9: right busy is held; mismatch applied, still busy before the edge
    @(negedge clk);
    drive(1'b1, 13'h1FFF, 1'b1, 13'h0000);
    #1;
    chk("R9 br before edge", right_busy_out, 1'b1);
    chk("R9 wr gated before edge", right_wr_ok, 1'b0);
    @(posedge clk); #1;
    chk("R9 br after edge", right_busy_out, 1'b0);
    chk("R9 wr after edge", right_wr_ok, 1'b1);

    // R6: no write request gives no qualifier
    @(negedge clk);
    left_wr = 1'b0;
    #1;
    chk("R6 no wr", left_wr_ok, 1'b0);
    left_wr = 1'b1;

    // R7 slave: internal match makes right busy internally, but it is ignored
    @(negedge clk);
    master_mode = 1'b0;
    drive(1'b1, 13'h0040, 1'b1, 13'h0000);
    @(posedge clk);
    @(negedge clk);
    drive(1'b1, 13'h0040, 1'b1, 13'h0040);
    @(posedge clk); #1;
    chk("R7 slave bl low", left_busy_out, 1'b0);
    chk("R7 slave br low", right_busy_out, 1'b0);
    chk("R7 slave internal ignored wr", right_wr_ok, 1'b1);
    @(negedge clk);
    left_busy_in = 1'b1;
    #1;
    chk("R7 slave left blocked", left_wr_ok, 1'b0);
    chk("R7 slave right free", right_wr_ok, 1'b1);
    left_busy_in = 1'b0; right_busy_in = 1'b1;
    #1;
    chk("R7 slave right blocked", right_wr_ok, 1'b0);
    chk("R7 slave left free", left_wr_ok, 1'b1);
    right_busy_in = 1'b0;

    // back to master: held internal result shows immediately (R5)
    @(negedge clk);
    master_mode = 1'b1;
    #1;
    chk("R5 master resumes br", right_busy_out, 1'b1);
    chk("R6 master wr gated", right_wr_ok, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule